// File: doc/BRIEF.md
# Program-Counter Trace Sampler

This block is a per-thread sampling engine that builds a trace of where the program counter was, without raising an interrupt. A control word supplies an enable, a mode select and the base address of a circular buffer in memory. A trace-configuration word supplies the sample period and the buffer size. While sampling is active, a 32-bit interval counter starts at the period value and counts processor cycles. When it rolls past all ones, the block snapshots the program counter, the interval counter, a second event count and a free-running timestamp into a four-word record. It then reloads the period and writes the record to memory through a request/acknowledge port.

Records go into the buffer one after another. When the buffer range is full, the write pointer wraps quietly back to the base. A sample that arrives while the previous record is still being written is discarded and counted. Clearing the enable lets the record in flight finish, stops sampling and rewinds the pointer to the base.

Top module: `trace_sampler`

## Requirements
- R1: After a synchronous reset, `mem_req` is 0 and `drop_count` is 0.
- R2: Sampling runs only while control bit 0 (vector bit 63, enable) is 1 and control bit 1 (vector bit 62, mode) is 1. Register bits are numbered from the most significant end. With enable 1 and mode 0, or with enable 0 and mode 1, no write request is made.
- R3: The period P sits in config bits 2:33 (vector bits 61:30). The first overflow falls 2^32-1-P cycles after the first active cycle. Later overflows follow every 2^32-P cycles, because the counter reloads P at each overflow. Word 3 of each record carries the timestamp of the overflow cycle.
- R4: A record is four 64-bit words at consecutive 8-byte addresses, in this order: the program counter in the overflow cycle; the zero-extended interval counter (0xFFFFFFFF); the count of `evt_in` cycles since sampling became active, up to but not including the overflow cycle; and the timestamp, which counts cycles since reset.
- R5: Control bits 8:50 (vector bits 55:13) hold byte-address bits 55:13 of the base. Size code N in config bits 48:50 (vector bits 15:13) gives a buffer of 4096<<N bytes. The address of word k is base | ((8k) mod size), so the pointer wraps silently.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R7: An overflow that occurs while a record is still being written, up to and including the cycle of its last acknowledge, is dropped and adds exactly 1 to `drop_count`. With no such overlap, `drop_count` does not change.
- R8: Clearing the enable lets the record in flight complete and starts no new record. Sampling that is enabled again writes its first word at the base address.
- R9: The sample-select field (config bits 0:1), the event-select fields (config bits 34:47), the scope field (control bits 4:6) and the reserved bits have no effect on the records written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 64 | Control word: enable, mode, scope, buffer base |
| cfg_word | input | 64 | Trace configuration: sample select, period, event selects, size code |
| pc_in | input | 64 | Current program counter of the thread |
| evt_in | input | 1 | Second event, counted once per cycle while high |
| mem_req | output | 1 | Write request, held until acknowledged |
| mem_addr | output | 64 | Byte address of the word being written |
| mem_wdata | output | 64 | Record word being written |
| mem_ack | input | 1 | Memory accepts the current word |
| drop_count | output | 16 | Number of samples dropped because a record was in flight |

## Verification
The bench feeds the sampler several combinations of period, acknowledge latency, event activity and size code. The timestamp spacing confirms the reload interval. The program-counter word and the event word confirm that the snapshot is taken in the overflow cycle itself. Two long runs use the same period and differ only in size code. Only the 4 KiB buffer wraps to the base after 128 records, which tells the size decode apart from a fixed mask. A run with a period shorter than a record write confirms that every other sample is dropped. A mid-record disable confirms that the record completes and that the next run restarts at the base.

// File: rtl/smp_pkg.sv
package smp_pkg;
    localparam int REG_W      = 64;
    localparam int DATA_W     = 64;
    localparam int CNT_W      = 32;
    localparam int SZ_W       = 3;
    localparam int MIN_BUF_LG = 12;
    localparam int OFF_W      = MIN_BUF_LG + (1 << SZ_W) - 1;
    localparam int WORD_BYTES = 8;
    localparam int REC_WORDS  = 4;
    localparam int IDX_W      = $clog2(REC_WORDS);

    // Registers number bit 0 as the most significant bit.
    localparam int EN_POS   = REG_W - 1 - 0;
    localparam int MODE_POS = REG_W - 1 - 1;
    localparam int BASE_HI  = REG_W - 1 - 8;
    localparam int BASE_LO  = REG_W - 1 - 50;
    localparam int PER_HI   = REG_W - 1 - 2;
    localparam int PER_LO   = REG_W - 1 - 33;
    localparam int SZ_HI    = REG_W - 1 - 48;
    localparam int SZ_LO    = REG_W - 1 - 50;

    typedef enum logic [IDX_W-1:0] {
        W_PC   = 2'd0,
        W_SCNT = 2'd1,
        W_EV   = 2'd2,
        W_TS   = 2'd3
    } word_e;

    typedef struct packed {
        logic              en;
        logic              trace;
        logic [DATA_W-1:0] base;
    } ctl_t;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [SZ_W-1:0]  size;
    } cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] scnt;
        logic [DATA_W-1:0] ev;
        logic [DATA_W-1:0] ts;
    } rec_t;

    function automatic ctl_t decode_ctl(input logic [REG_W-1:0] w);
        ctl_t c;
        c.en    = w[EN_POS];
        c.trace = w[MODE_POS];
        c.base  = '0;
        c.base[BASE_HI:BASE_LO] = w[BASE_HI:BASE_LO];
        return c;
    endfunction

    function automatic cfg_t decode_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.period = w[PER_HI:PER_LO];
        c.size   = w[SZ_HI:SZ_LO];
        return c;
    endfunction

    function automatic logic [OFF_W-1:0] off_mask(input logic [SZ_W-1:0] size);
        logic [OFF_W-1:0] ones;
        logic [SZ_W-1:0]  top;
        ones = '1;
        top  = '1;
        return ones >> (top - size);
    endfunction

    function automatic logic [DATA_W-1:0] rec_word(input rec_t r, input word_e k);
        logic [DATA_W-1:0] w;
        case (k)
            W_PC:    w = r.pc;
            W_SCNT:  w = r.scnt;
            W_EV:    w = r.ev;
            default: w = r.ts;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/smp_interval_ctr.sv
module smp_interval_ctr
    import smp_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    assign ovf = active && (cnt == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!active || ovf) begin
            cnt <= period;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == $past(period)));
endmodule

// File: rtl/smp_event_ctrs.sv
module smp_event_ctrs #(
    parameter int EV_W = 32,
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            evt,
    output logic [EV_W-1:0] ev_cnt,
    output logic [TS_W-1:0] ts
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_cnt <= '0;
            ts     <= '0;
        end else begin
            ts <= ts + 1'b1;
            if (!active) begin
                ev_cnt <= '0;
            end else if (evt) begin
                ev_cnt <= ev_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smp_record_writer.sv
module smp_record_writer
    import smp_pkg::*;
#(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              ovf,
    input  rec_t              rec_in,
    input  logic [DATA_W-1:0] base,
    input  logic [SZ_W-1:0]   size,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

    logic              busy;
    logic [IDX_W-1:0]  idx;
    rec_t              rec_q;
    logic [DATA_W-1:0] base_q;
    logic [SZ_W-1:0]   size_q;
    logic [OFF_W-1:0]  off;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            idx        <= '0;
            rec_q      <= '0;
            base_q     <= '0;
            size_q     <= '0;
            off        <= '0;
            drop_count <= '0;
        end else if (busy) begin
            if (mem_ack) begin
                off <= (off + OFF_W'(WORD_BYTES)) & off_mask(size_q);
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (ovf) begin
                drop_count <= drop_count + 1'b1;
            end
        end else if (ovf) begin
            busy   <= 1'b1;
            idx    <= '0;
            rec_q  <= rec_in;
            base_q <= base;
            size_q <= size;
        end else if (!active) begin
            off <= '0;
        end
    end

    assign mem_req   = busy;
    assign mem_addr  = base_q | {{(DATA_W-OFF_W){1'b0}}, off};
    assign mem_wdata = rec_word(rec_q, word_e'(idx));

    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

    // R5
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R4
    rec_end_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && (idx == LAST_IDX)) |=> !mem_req);
endmodule

// File: rtl/trace_sampler.sv
module trace_sampler
    import smp_pkg::*;
#(
    parameter int EV_W   = 32,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  ctl_word,
    input  logic [REG_W-1:0]  cfg_word,
    input  logic [DATA_W-1:0] pc_in,
    input  logic              evt_in,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic [DROP_W-1:0] drop_count
);
    ctl_t              ctl;
    cfg_t              cfg;
    logic              active;
    logic [CNT_W-1:0]  cnt;
    logic              ovf;
    logic [EV_W-1:0]   ev_cnt;
    logic [DATA_W-1:0] ev_wide;
    logic [DATA_W-1:0] ts;
    rec_t              snap;

    assign ctl    = decode_ctl(ctl_word);
    assign cfg    = decode_cfg(cfg_word);
    assign active = ctl.en && ctl.trace;

    smp_interval_ctr #(.W(CNT_W)) u_ictr (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .period (cfg.period),
        .cnt    (cnt),
        .ovf    (ovf)
    );

    smp_event_ctrs #(.EV_W(EV_W), .TS_W(DATA_W)) u_ectr (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .evt    (evt_in),
        .ev_cnt (ev_cnt),
        .ts     (ts)
    );

    generate
        if (EV_W < DATA_W) begin : g_ev_ext
            assign ev_wide = {{(DATA_W-EV_W){1'b0}}, ev_cnt};
        end else begin : g_ev_cut
            assign ev_wide = ev_cnt[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        snap.pc   = pc_in;
        snap.scnt = {{(DATA_W-CNT_W){1'b0}}, cnt};
        snap.ev   = ev_wide;
        snap.ts   = ts;
    end

    smp_record_writer #(.DROP_W(DROP_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .ovf        (ovf),
        .rec_in     (snap),
        .base       (ctl.base),
        .size       (cfg.size),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .drop_count (drop_count)
    );
endmodule

// File: tb/sim_trace_sampler.sv
module sim_trace_sampler;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h0000_00AB_CD00_0000;

    typedef struct packed {
        logic [31:0] len;
        logic [3:0]  lat;
        logic        evt;
        logic [2:0]  sz;
        logic        junk;
        logic [15:0] nrec;
        logic [31:0] last_off;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{32'd16, 4'd0, 1'b1, 3'd0, 1'b0, 16'd3,   32'h58},
        '{32'd40, 4'd2, 1'b0, 3'd1, 1'b1, 16'd3,   32'h58},
        '{32'd9,  4'd1, 1'b1, 3'd2, 1'b0, 16'd4,   32'h78},
        '{32'd16, 4'd0, 1'b1, 3'd0, 1'b0, 16'd130, 32'h38},
        '{32'd16, 4'd0, 1'b1, 3'd2, 1'b0, 16'd130, 32'h1038}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] ctl_word = '0;
    logic [63:0] cfg_word = '0;
    logic [63:0] pc_in;
    logic        evt_in = 1'b0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] drop_count;
    logic [63:0] bc;

    trace_sampler u0 (
        .clk(clk), .rst(rst), .ctl_word(ctl_word), .cfg_word(cfg_word),
        .pc_in(pc_in), .evt_in(evt_in), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .drop_count(drop_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) bc <= '0;
        else     bc <= bc + 64'd1;
    end
    assign pc_in = 64'h4000 + {bc[61:0], 2'b00};

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    int cur_L, cur_lat, cur_step, cur_sz;
    bit cur_evt;
    logic [63:0] v_en;
    int nwords, nrecs, widx, waited;
    bit word_open;
    logic [63:0] snap_a, snap_d, last_addr;
    logic [63:0] rbuf [4];
    string atag = "R5";

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ctl(input bit en, input bit tr,
                                           input logic [63:0] base, input bit junk);
        logic [63:0] c;
        c = '0;
        c[63] = en;
        c[62] = tr;
        c[55:13] = base[55:13];
        if (junk) begin
            c[61:60] = 2'b11;
            c[59:57] = 3'b101;
            c[56]    = 1'b1;
            c[12:0]  = 13'h0F0F;
        end
        return c;
    endfunction

    function automatic logic [63:0] mk_cfg(input int len, input int sz, input bit junk);
        logic [63:0] c;
        logic [31:0] p;
        p = 32'h0 - 32'(len);
        c = '0;
        c[61:30] = p;
        c[15:13] = 3'(sz);
        if (junk) begin
            c[63:62] = 2'b10;
            c[29:16] = 14'h2A5C;
            c[12:0]  = 13'h1ABC;
        end
        return c;
    endfunction

    function automatic logic [63:0] exp_addr(input int n);
        logic [63:0] mask;
        mask = (64'd4096 << cur_sz) - 64'd1;
        return BASE | ((64'(n) * 64'd8) & mask);
    endfunction

    task automatic check_rec();
        logic [63:0] ets;
        ets = v_en + 64'(cur_L) - 64'd1 + 64'(nrecs) * 64'(cur_step) * 64'(cur_L);
        chk_eq("R3", "timestamp word", rbuf[3], ets);
        chk_eq("R4", "pc word", rbuf[0], 64'h4000 + ets * 64'd4);
        chk_eq("R4", "interval word", rbuf[1], 64'h0000_0000_FFFF_FFFF);
        chk_eq("R4", "event word", rbuf[2], cur_evt ? (ets - v_en) : 64'd0);
    endtask

    task automatic take_word();
        chk_eq(atag, "word address", mem_addr, exp_addr(nwords));
        last_addr = mem_addr;
        rbuf[widx] = mem_wdata;
        widx++;
        nwords++;
        if (widx == 4) begin
            widx = 0;
            check_rec();
            nrecs++;
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (mem_req) begin
            if (!word_open) begin
                word_open = 1'b1;
                waited = 0;
                snap_a = mem_addr;
                snap_d = mem_wdata;
            end else begin
                chk_eq("R6", "addr held", mem_addr, snap_a);
                chk_eq("R6", "data held", mem_wdata, snap_d);
            end
            if (waited < cur_lat) begin
                mem_ack = 1'b0;
                waited++;
            end else begin
                mem_ack = 1'b1;
                word_open = 1'b0;
                take_word();
            end
        end else begin
            mem_ack = 1'b0;
            word_open = 1'b0;
        end
    endtask

    task automatic begin_run(input int len, input int lat, input bit evt,
                             input int sz, input bit junk, input int stp);
        @(negedge clk);
        ctl_word = '0;
        mem_ack = 1'b0;
        cfg_word = mk_cfg(len, sz, junk);
        evt_in = evt;
        cur_L = len; cur_lat = lat; cur_evt = evt; cur_sz = sz; cur_step = stp;
        nwords = 0; nrecs = 0; widx = 0; word_open = 1'b0;
        repeat (2) @(negedge clk);
        ctl_word = mk_ctl(1'b1, 1'b1, BASE, junk);
        v_en = bc;
    endtask

    task automatic collect(input int n);
        int guard = 0;
        while (nrecs < n && guard < 20000) begin
            step();
            guard++;
        end
    endtask

    task automatic stop_and_drain();
        int idle = 0;
        int guard = 0;
        ctl_word = '0;
        while (idle < 30 && guard < 2000) begin
            step();
            idle = mem_req ? 0 : idle + 1;
            guard++;
        end
        mem_ack = 1'b0;
    endtask

    initial begin
        logic [15:0] d0;
        int reqs;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk_eq("R1", "req in reset", 64'(mem_req), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1", "req after reset", 64'(mem_req), 64'd0);
        chk_eq("R1", "drops after reset", 64'(drop_count), 64'd0);

        // R2: accumulation mode and disabled trace mode write nothing
        cfg_word = mk_cfg(16, 0, 1'b0);
        ctl_word = mk_ctl(1'b1, 1'b0, BASE, 1'b0);
        reqs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk_eq("R2", "requests in accumulation mode", 64'(reqs), 64'd0);
        ctl_word = mk_ctl(1'b0, 1'b1, BASE, 1'b0);
        reqs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk_eq("R2", "requests with enable clear", 64'(reqs), 64'd0);

        // Table of runs: interval, latency, event, size, ignored fields
        d0 = drop_count;
        for (int k = 0; k < 5; k++) begin
            atag = "R5";
            begin_run(int'(VECS[k].len), int'(VECS[k].lat), VECS[k].evt,
                      int'(VECS[k].sz), VECS[k].junk, 1);
            collect(int'(VECS[k].nrec));
            chk_eq("R3", "records collected", 64'(nrecs), 64'(VECS[k].nrec));
            chk_eq("R5", "last word address", last_addr, BASE | 64'(VECS[k].last_off));
            if (VECS[k].junk)
                chk_eq("R9", "records with ignored fields set", 64'(nrecs), 64'(VECS[k].nrec));
            stop_and_drain();
            chk_eq("R7", "no drops on long interval", 64'(drop_count), 64'(d0));
        end

        // R7: interval of 4 cycles is shorter than a record write
        d0 = drop_count;
        begin_run(4, 0, 1'b1, 0, 1'b0, 2);
        collect(4);
        chk_eq("R7", "drops after four records", 64'(drop_count), 64'(d0) + 64'd3);
        stop_and_drain();

        // R8: disable in the middle of a record
        begin_run(16, 2, 1'b1, 0, 1'b0, 1);
        begin
            int guard = 0;
            while (!word_open && nwords == 0 && guard < 1000) begin
                step();
                guard++;
            end
        end
        ctl_word = '0;
        for (int i = 0; i < 200; i++) step();
        chk_eq("R8", "words after mid-record disable", 64'(nwords), 64'd4);
        chk_eq("R8", "records after mid-record disable", 64'(nrecs), 64'd1);
        atag = "R8";
        begin_run(16, 0, 1'b1, 0, 1'b0, 1);
        collect(1);
        chk_eq("R8", "first address after re-enable", rbuf[0] == 64'h0 ? 64'h0 : last_addr,
               BASE + 64'd24);
        stop_and_drain();
        atag = "R5";

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule